// File: doc/BRIEF.md
# Linear Image Sensor Readout Controller

This block sits in an FPGA next to a 128-pixel linear photodiode array and generates the two digital inputs that the sensor needs: its pixel clock and a one-clock start pulse that begins each readout. The pixel clock is derived from the system clock. A configurable half-period sets its rate. Each start pulse also ends one exposure and begins the next, so the spacing between start pulses sets the integration time. The sensor resets its integrators for 18 clocks after each start pulse, and integration runs from there to the following start pulse.

For each of the first 128 rising edges of a frame, the controller raises a one-cycle sample strobe and gives the 0-based pixel index with it. The strobe comes a set number of system clocks after the rising edge, so that the analog output has settled before an external converter samples it. A completion pulse follows the strobe of the last pixel.

A frame runs for a set number of sensor clocks, which must be at least 130. In single-shot mode one frame runs per start request. In continuous mode frames follow back to back. Every configuration value is clamped into its legal range and is captured at the start of each frame.

Top module: `lsr_ctrl`

## Requirements
- R1: After reset, and before any start request, sclk_o, si_o, pix_valid_o and frame_done_o are all low.
- R2: While a frame runs, each high phase and each low phase of sclk_o lasts H system clocks. H is half_div_i clamped to the range [HALF_LO, MAX_HALF]. HALF_LO is the larger of MIN_HALF and (MIN_DLY+2)/2, which is 13 with the default parameters.
- R3: A start request sampled at edge E0 drives si_o high from E0. si_o goes low at edge E0+2H, the falling edge that follows the first rising edge of sclk_o at E0+H. si_o therefore spans exactly one rising edge and never changes at a rising edge.
- R4: A frame contains F rising edges of sclk_o, at edges E0+(2r-1)H for r = 1..F, and ends on the falling edge at E0+2FH. F is frame_len_i clamped to a minimum of N_PIX+2 (130).
- R5: For rising edges r = 1..N_PIX, pix_valid_o is high for exactly one cycle, D system clocks after the edge at which sclk_o rose. pix_idx_o is r-1 during that cycle. Rising edges after the N_PIX-th give no strobe.
- R6: D is smp_dly_i clamped to the range [MIN_DLY, 2H-1]. MIN_DLY is 24 by default, which is 120 ns at 200 MHz.
- R7: frame_done_o is high for one cycle, on the cycle right after the strobe for pixel index N_PIX-1.
- R8: In single-shot mode (cont_i low at the end of the frame), sclk_o and si_o stay low after the frame ends until the next start request. A start request that arrives while a frame is running is ignored.
- R9: If cont_i is high at the final falling edge, the next frame begins on that same edge, so the start-pulse spacing is 2HF system clocks. The configuration inputs are captured again at that edge and apply to the new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a frame while idle |
| cont_i | input | 1 | Continuous mode: chain frames back to back |
| half_div_i | input | 16 | Sensor clock half-period in system clocks |
| frame_len_i | input | 16 | Frame length in sensor clocks |
| smp_dly_i | input | 16 | Delay from a sensor rising edge to the sample strobe, in system clocks |
| sclk_o | output | 1 | Sensor pixel clock |
| si_o | output | 1 | Sensor start pulse |
| pix_valid_o | output | 1 | Sample strobe for the converter |
| pix_idx_o | output | 7 | Pixel index with the strobe (0-based) |
| frame_done_o | output | 1 | One-cycle pulse after the last pixel strobe |

## Verification
The bench drives every configuration input below its lower limit and above its upper limit. A missing or reversed clamp shows up as sensor edges and strobes on the wrong cycles. One case sets the delay to 100 with a 13-cycle half period. A design without the upper delay clamp would place the strobe after the next rising edge, or collide with it. A continuous run changes the half period and the delay part way through the first frame. A design that latched the new values at the wrong time would shift every edge of that frame, and one that never latched them again would shift the later frames. A start pulse in the middle of a frame, followed by idle checks, catches a controller that restarts itself or keeps clocking the sensor after a single-shot frame.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  parameter int unsigned CW = 16;

  typedef struct packed {
    logic [CW-1:0] half;
    logic [CW-1:0] frame;
    logic [CW-1:0] dly;
  } lsr_cfg_t;
endpackage

// File: rtl/lsr_cfg_clamp.sv
module lsr_cfg_clamp
  import lsr_pkg::*;
#(
  parameter int unsigned N_PIX    = 128,
  parameter int unsigned MIN_HALF = 10,
  parameter int unsigned MAX_HALF = 20000,
  parameter int unsigned MIN_DLY  = 24
) (
  input  logic [CW-1:0] half_i,
  input  logic [CW-1:0] frame_i,
  input  logic [CW-1:0] dly_i,
  output lsr_cfg_t      cfg_o
);
  localparam int unsigned HALF_DLY = (MIN_DLY + 2) / 2;
  localparam int unsigned HALF_LO  = (MIN_HALF > HALF_DLY) ? MIN_HALF : HALF_DLY;
  localparam logic [CW-1:0] HALF_LO_C  = CW'(HALF_LO);
  localparam logic [CW-1:0] HALF_HI_C  = CW'(MAX_HALF);
  localparam logic [CW-1:0] FRAME_LO_C = CW'(N_PIX + 2);
  localparam logic [CW-1:0] DLY_LO_C   = CW'(MIN_DLY);

  logic [CW-1:0] half_c;
  logic [CW:0]   per_m1;

  always_comb begin
    if (half_i < HALF_LO_C)      half_c = HALF_LO_C;
    else if (half_i > HALF_HI_C) half_c = HALF_HI_C;
    else                         half_c = half_i;
    per_m1 = {half_c, 1'b0} - {{CW{1'b0}}, 1'b1};

    cfg_o.half  = half_c;
    cfg_o.frame = (frame_i < FRAME_LO_C) ? FRAME_LO_C : frame_i;
    // strobe must land before the next rising edge
    if (dly_i < DLY_LO_C)                 cfg_o.dly = DLY_LO_C;
    else if ({1'b0, dly_i} > per_m1)      cfg_o.dly = per_m1[CW-1:0];
    else                                  cfg_o.dly = dly_i;
  end
endmodule

// File: rtl/lsr_sclk_gen.sv
module lsr_sclk_gen
  import lsr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] half_i,
  output logic          sclk_o,
  output logic          rise_o,
  output logic          fall_o
);
  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          term;

  assign term   = run_i && (cnt_q == half_i - CW'(1));
  assign rise_o = term && !sclk_q;
  assign fall_o = term && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (term) begin
      cnt_q  <= '0;
      sclk_q <= !sclk_q;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/lsr_frame_seq.sv
module lsr_frame_seq
  import lsr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cont_i,
  input  lsr_cfg_t      cfg_i,
  input  logic          rise_i,
  input  logic          fall_i,
  output logic          run_o,
  output logic          si_o,
  output lsr_cfg_t      cfg_o,
  output logic [CW-1:0] rise_cnt_o
);
  logic          run_q;
  logic          si_q;
  logic [CW-1:0] cnt_q;
  lsr_cfg_t      cfg_q;

  assign run_o      = run_q;
  assign si_o       = si_q;
  assign cfg_o      = cfg_q;
  assign rise_cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      si_q  <= 1'b0;
      cnt_q <= '0;
      cfg_q <= '0;
    end else if (!run_q) begin
      if (start_i) begin
        run_q <= 1'b1;
        si_q  <= 1'b1;
        cnt_q <= '0;
        cfg_q <= cfg_i;
      end
    end else begin
      if (rise_i) cnt_q <= cnt_q + CW'(1);
      if (fall_i) begin
        if (cnt_q == CW'(1)) si_q <= 1'b0;
        if (cnt_q == cfg_q.frame) begin
          cnt_q <= '0;
          if (cont_i) begin
            si_q  <= 1'b1;
            cfg_q <= cfg_i;
          end else begin
            run_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lsr_pix_strobe.sv
module lsr_pix_strobe
  import lsr_pkg::*;
#(
  parameter int unsigned N_PIX = 128,
  localparam int unsigned IDX_W = $clog2(N_PIX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic [CW-1:0]    rise_cnt_i,
  input  logic [CW-1:0]    dly_i,
  output logic             pix_valid_o,
  output logic [IDX_W-1:0] pix_idx_o,
  output logic             frame_done_o
);
  logic             pend_q;
  logic [CW-1:0]    cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             valid_q;
  logic [IDX_W-1:0] vidx_q;
  logic             done_q;

  assign pix_valid_o  = valid_q;
  assign pix_idx_o    = vidx_q;
  assign frame_done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
      vidx_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= valid_q && (vidx_q == IDX_W'(N_PIX - 1));
      if (rise_i && (rise_cnt_i < CW'(N_PIX))) begin
        pend_q <= 1'b1;
        cnt_q  <= dly_i - CW'(1);
        idx_q  <= rise_cnt_i[IDX_W-1:0];
      end else if (pend_q) begin
        if (cnt_q == '0) begin
          pend_q  <= 1'b0;
          valid_q <= 1'b1;
          vidx_q  <= idx_q;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lsr_ctrl.sv
module lsr_ctrl
  import lsr_pkg::*;
#(
  parameter int unsigned N_PIX    = 128,
  parameter int unsigned MIN_HALF = 10,
  parameter int unsigned MAX_HALF = 20000,
  parameter int unsigned MIN_DLY  = 24,
  localparam int unsigned IDX_W   = $clog2(N_PIX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic [CW-1:0]    half_div_i,
  input  logic [CW-1:0]    frame_len_i,
  input  logic [CW-1:0]    smp_dly_i,
  output logic             sclk_o,
  output logic             si_o,
  output logic             pix_valid_o,
  output logic [IDX_W-1:0] pix_idx_o,
  output logic             frame_done_o
);
  lsr_cfg_t      cfg_in;
  lsr_cfg_t      cfg_act;
  logic          run;
  logic          rise;
  logic          fall;
  logic [CW-1:0] rise_cnt;

  lsr_cfg_clamp #(
    .N_PIX(N_PIX), .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF), .MIN_DLY(MIN_DLY)
  ) i_clamp (
    .half_i (half_div_i),
    .frame_i(frame_len_i),
    .dly_i  (smp_dly_i),
    .cfg_o  (cfg_in)
  );

  lsr_frame_seq i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cont_i    (cont_i),
    .cfg_i     (cfg_in),
    .rise_i    (rise),
    .fall_i    (fall),
    .run_o     (run),
    .si_o      (si_o),
    .cfg_o     (cfg_act),
    .rise_cnt_o(rise_cnt)
  );

  lsr_sclk_gen i_sclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .half_i(cfg_act.half),
    .sclk_o(sclk_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  lsr_pix_strobe #(.N_PIX(N_PIX)) i_strobe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .rise_cnt_i  (rise_cnt),
    .dly_i       (cfg_act.dly),
    .pix_valid_o (pix_valid_o),
    .pix_idx_o   (pix_idx_o),
    .frame_done_o(frame_done_o)
  );
endmodule

// File: rtl/lsr_ctrl_chk.sv
module lsr_ctrl_chk
  import lsr_pkg::*;
#(
  parameter int unsigned N_PIX    = 128,
  parameter int unsigned MIN_HALF = 10,
  parameter int unsigned MIN_DLY  = 24,
  localparam int unsigned IDX_W   = $clog2(N_PIX)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sclk_o,
  input logic             si_o,
  input logic             pix_valid_o,
  input logic [IDX_W-1:0] pix_idx_o,
  input logic             frame_done_o
);
  localparam int unsigned HALF_DLY = (MIN_DLY + 2) / 2;
  localparam int unsigned HALF_LO  = (MIN_HALF > HALF_DLY) ? MIN_HALF : HALF_DLY;

  logic [CW-1:0] hi_len;
  logic [CW-1:0] lo_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_len <= '0;
      lo_len <= '1;
    end else begin
      if (sclk_o) begin
        lo_len <= '0;
        if (hi_len != '1) hi_len <= hi_len + CW'(1);
      end else begin
        hi_len <= '0;
        if (lo_len != '1) lo_len <= lo_len + CW'(1);
      end
    end
  end

  a_r2_min_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> hi_len >= CW'(HALF_LO));

  a_r2_min_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> lo_len >= CW'(HALF_LO));

  a_r3_si_stable_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(si_o));

  a_r3_si_up_while_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(si_o) |-> !sclk_o);

  a_r5_strobe_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |=> !pix_valid_o);

  a_r7_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && pix_idx_o == IDX_W'(N_PIX - 1)) |=> frame_done_o);
endmodule

bind lsr_ctrl lsr_ctrl_chk #(
  .N_PIX(N_PIX), .MIN_HALF(MIN_HALF), .MIN_DLY(MIN_DLY)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sclk_o      (sclk_o),
  .si_o        (si_o),
  .pix_valid_o (pix_valid_o),
  .pix_idx_o   (pix_idx_o),
  .frame_done_o(frame_done_o)
);

// File: tb/test_lsr_ctrl.sv
`timescale 1ns/1ps
module test_lsr_ctrl;
  localparam int N = 128;
  localparam int MAXH = 40;
  localparam int HLO = 13;
  localparam int FLO = 130;
  localparam int DLO = 24;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cont = 1'b0;
  logic [15:0] half_div = 16'd20;
  logic [15:0] frame_len = 16'd140;
  logic [15:0] smp_dly = 16'd30;
  logic sclk, si, pvalid, fdone;
  logic [6:0] pidx;

  always #2.5 clk = ~clk;

  lsr_ctrl #(.MAX_HALF(MAXH)) i_lsr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cont_i(cont),
    .half_div_i(half_div), .frame_len_i(frame_len), .smp_dly_i(smp_dly),
    .sclk_o(sclk), .si_o(si), .pix_valid_o(pvalid), .pix_idx_o(pidx),
    .frame_done_o(fdone)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int qs_rise[$], qs_fall[$], qsi_rise[$], qsi_fall[$], qv_t[$], qv_i[$], qd[$];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic unexpected(input string tag);
    n_chk++;
    n_fail++;
    $display("FAIL %s: actual event at cycle %0d expected none", tag, cyc);
  endtask

  function automatic int cl_h(input int h);
    return (h < HLO) ? HLO : ((h > MAXH) ? MAXH : h);
  endfunction
  function automatic int cl_f(input int f);
    return (f < FLO) ? FLO : f;
  endfunction
  function automatic int cl_d(input int d, input int h);
    int hc = cl_h(h);
    return (d < DLO) ? DLO : ((d > 2*hc-1) ? 2*hc-1 : d);
  endfunction

  // scoreboard driver side: expected event times for one frame
  task automatic push_frame(input int e0, input int h, input int f, input int d);
    qsi_rise.push_back(e0);
    qsi_fall.push_back(e0 + 2*h);
    for (int r = 1; r <= f; r++) begin
      qs_rise.push_back(e0 + (2*r-1)*h);
      qs_fall.push_back(e0 + 2*r*h);
    end
    for (int p = 1; p <= N; p++) begin
      qv_t.push_back(e0 + (2*p-1)*h + d);
      qv_i.push_back(p-1);
    end
    qd.push_back(e0 + (2*N-1)*h + d + 1);
  endtask

  function automatic int pending();
    return qs_rise.size() + qs_fall.size() + qsi_rise.size() + qsi_fall.size()
         + qv_t.size() + qd.size();
  endfunction

  // monitor: compare observed edges and strobes against the queues
  logic sclk_p = 1'b0, si_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && !sclk_p) begin
        if (qs_rise.size() == 0) unexpected("R2 R4 R8 sclk rise");
        else chk("R2 R4 sclk rise cycle", cyc, qs_rise.pop_front());
      end
      if (!sclk && sclk_p) begin
        if (qs_fall.size() == 0) unexpected("R2 R4 sclk fall");
        else chk("R2 R4 sclk fall cycle", cyc, qs_fall.pop_front());
      end
      if (si && !si_p) begin
        if (qsi_rise.size() == 0) unexpected("R3 R8 R9 si rise");
        else chk("R3 R9 si rise cycle", cyc, qsi_rise.pop_front());
      end
      if (!si && si_p) begin
        if (qsi_fall.size() == 0) unexpected("R3 si fall");
        else chk("R3 si fall cycle", cyc, qsi_fall.pop_front());
      end
      if (pvalid) begin
        if (qv_t.size() == 0) unexpected("R5 strobe");
        else begin
          chk("R5 R6 strobe cycle", cyc, qv_t.pop_front());
          chk("R5 strobe index", int'(pidx), qv_i.pop_front());
        end
      end
      if (fdone) begin
        if (qd.size() == 0) unexpected("R7 frame done");
        else chk("R7 frame done cycle", cyc, qd.pop_front());
      end
    end
    sclk_p <= sclk;
    si_p <= si;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(negedge clk) begin
    if (cyc >= LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, LIMIT);
      summary();
      $finish;
    end
  end

  task automatic set_cfg(input int h, input int f, input int d);
    half_div = 16'(h);
    frame_len = 16'(f);
    smp_dly = 16'(d);
  endtask

  task automatic drain_and_idle();
    while (pending() > 0) @(negedge clk);
    repeat (60) @(negedge clk);
    chk("R8 sclk idle", int'(sclk), 0);
    chk("R8 si idle", int'(si), 0);
    chk("R8 no leftover", pending(), 0);
  endtask

  task automatic run_single(input int h, input int f, input int d, input bit poke);
    int e0;
    @(negedge clk);
    set_cfg(h, f, d);
    start = 1'b1;
    e0 = cyc + 1;
    push_frame(e0, cl_h(h), cl_f(f), cl_d(d, h));
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R8: start request in mid-frame must be ignored
      repeat (500) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    drain_and_idle();
  endtask

  initial begin
    int e0, e1, e2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sclk", int'(sclk), 0);
    chk("R1 si", int'(si), 0);
    chk("R1 strobe", int'(pvalid), 0);
    chk("R1 done", int'(fdone), 0);

    run_single(20, 140, 30, 1'b0);   // nominal
    run_single(2, 10, 1, 1'b0);      // R2 R4 R6 lower clamps
    run_single(13, 130, 100, 1'b0);  // R6 upper clamp -> 25
    run_single(60, 130, 50, 1'b0);   // R2 upper clamp -> 40
    run_single(15, 130, 24, 1'b1);   // R8 start while busy

    // R9 continuous mode with a configuration change in frame 1
    @(negedge clk);
    set_cfg(14, 131, 24);
    cont = 1'b1;
    start = 1'b1;
    e0 = cyc + 1;
    e1 = e0 + 2*14*131;
    e2 = e1 + 2*16*131;
    push_frame(e0, 14, 131, 24);
    push_frame(e1, 16, 131, 27);
    push_frame(e2, 16, 131, 27);
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    set_cfg(16, 131, 27);
    while (cyc < e2 + 100) @(negedge clk);
    cont = 1'b0;
    drain_and_idle();

    summary();
    $finish;
  end
endmodule